// File: doc/BRIEF.md
# Byte-masked write-combining cache

This block is a small write-only cache that absorbs stores without ever fetching the target line from the level below. Each resident line keeps one dirty flag per byte. Later stores to the same line merge into it byte by byte, so different writers can fill disjoint bytes of one line without conflict. A store is taken in a single cycle and never returns an acknowledgement.

Loads probe the cache and are answered only when every requested byte is dirty in the resident line. When a load finds its line resident but only partly covered, the cache first pushes that line's dirty bytes downstream. It then answers "miss", so the requester can forward the read to the next level and see the merged data there.

Lines leave the cache in three ways: replacement by a store to the same index under a different tag, a partial-hit load, or an evict request that names a line address. The evict request is intended to come from an external ordering FIFO. Every write-back goes out on a valid/ready port as data plus a byte mask, and at the same moment a one-cycle invalidate pulse carries the line address to a companion read cache. All addresses on the ports are line addresses (byte address divided by the line size). Index bits are the low `log2(NLINES)` bits and the tag is the rest. The cache is direct-mapped, with 16 lines of 64 bytes by default. When requests arrive in the same cycle, an evict request is served first, then a store, then a load.

Top module: `wcache_wc`

## Requirements
- R1: With no write-back pending and no evict request, `st_ready` is high and a store is taken in that cycle without any downstream read. A store whose byte enables are all zero changes nothing: it writes nothing back and leaves the resident line as it was.
- R2: Every line holds one dirty bit per byte; bit b of `wb_mask` marks byte b, which sits at `wb_data[8b+7:8b]`. A write-back carries exactly the dirty bytes of the line and never an empty mask.
- R3: A line stays resident until it is replaced or an evict request names its address. An evict of a resident line writes it back and frees it.
- R4: A load whose requested bytes (`ld_mask`) are all dirty in the resident line gets `rsp_valid` with `rsp_hit`=1 in the cycle after it is accepted, carrying the stored bytes.
- R5: A load whose line is resident but not fully covered causes a write-back of that line and frees it. `rsp_valid` with `rsp_hit`=0 follows in the cycle after the write-back handshake. A load to a non-resident line gets a miss in the next cycle with no write-back.
- R6: Stores to different bytes of the same resident line merge. A later store to a dirty byte overwrites only that byte.
- R7: A store to an index held by a line with another tag writes back the old line's dirty bytes. It then allocates the new line with only the stored bytes dirty.
- R8: Every accepted write-back (`wb_valid` and `wb_ready` both high) raises `inv_valid` for exactly that cycle, with `inv_la` equal to `wb_la`.
- R9: `wb_valid` stays high with stable address, data and mask until `wb_ready` is seen. While it is high, `st_ready` and `ld_ready` are low.
- R10: An evict request for a line that is not resident is taken in the cycle it is raised, and no write-back follows.
- R11: In a hit response, bytes outside `ld_mask` read as zero. A miss response carries all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store taken this cycle |
| st_la | input | LA_W | Store line address |
| st_data | input | LINE_BYTES*8 | Store data, byte b at bits 8b+7:8b |
| st_be | input | LINE_BYTES | Store byte enables |
| ld_valid | input | 1 | Load probe request |
| ld_ready | output | 1 | Load taken this cycle |
| ld_la | input | LA_W | Load line address |
| ld_mask | input | LINE_BYTES | Requested bytes |
| rsp_valid | output | 1 | Load response |
| rsp_hit | output | 1 | 1 = served here, 0 = forward to next level |
| rsp_data | output | LINE_BYTES*8 | Response data |
| ev_valid | input | 1 | Evict-by-address request |
| ev_ready | output | 1 | Evict request taken |
| ev_la | input | LA_W | Line address to evict |
| wb_valid | output | 1 | Write-back valid |
| wb_ready | input | 1 | Downstream accepts write-back |
| wb_la | output | LA_W | Write-back line address |
| wb_data | output | LINE_BYTES*8 | Write-back data |
| wb_mask | output | LINE_BYTES | Dirty bytes being written |
| inv_valid | output | 1 | One-cycle invalidate pulse |
| inv_la | output | LA_W | Line address to invalidate |

## Verification
The hardest situation to reach is a write-back that is held off by downstream back-pressure while other requests wait at the ports. The bench forces it by dropping `wb_ready` just before a store that collides with a resident line of another tag. It then watches for several cycles that the pending write-back holds still and that the store and load ports stay closed. A second case that needs care is the partial-hit load. The bench builds it from two stores from different writers to one line, then asks for one byte more than they covered, so that the merged mask, the write-back and the late miss response can all be checked in order.

// File: rtl/wcc_pkg.sv
`timescale 1ns/1ps
package wcc_pkg;
   typedef enum logic {
      S_IDLE  = 1'b0,
      S_DRAIN = 1'b1
   } wcc_state_e;

   typedef enum logic {
      P_NONE   = 1'b0,
      P_LDMISS = 1'b1
   } wcc_post_e;
endpackage

// File: rtl/wcc_array.sv
`timescale 1ns/1ps
module wcc_array #(
   parameter int NLINES     = 16,
   parameter int LINE_BYTES = 64,
   parameter int TAG_W      = 22,
   localparam int IDX_W     = $clog2(NLINES),
   localparam int LINE_BITS = LINE_BYTES * 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [TAG_W-1:0]      rd_tag,
   output logic [LINE_BYTES-1:0] rd_dirty,
   output logic [LINE_BITS-1:0]  rd_data,
   input  logic                  wr_en,
   input  logic                  wr_fresh,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [TAG_W-1:0]      wr_tag,
   input  logic [LINE_BITS-1:0]  wr_data,
   input  logic [LINE_BYTES-1:0] wr_be,
   input  logic                  clr_en,
   input  logic [IDX_W-1:0]      clr_idx
);
   logic [LINE_BITS-1:0]  data_q  [NLINES];
   logic [TAG_W-1:0]      tag_q   [NLINES];
   logic [LINE_BYTES-1:0] dirty_q [NLINES];
   logic [LINE_BITS-1:0]  old_line;
   logic [LINE_BITS-1:0]  merged;

   assign rd_tag   = tag_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_data  = data_q[rd_idx];
   assign old_line = data_q[wr_idx];

   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
      assign merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : old_line[b*8 +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NLINES; i++) dirty_q[i] <= '0;
      end else if (wr_en) begin
         dirty_q[wr_idx] <= wr_fresh ? wr_be : (dirty_q[wr_idx] | wr_be);
      end else if (clr_en) begin
         dirty_q[clr_idx] <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         data_q[wr_idx] <= merged;
         tag_q[wr_idx]  <= wr_tag;
      end
   end
endmodule

// File: rtl/wcc_lookup.sv
`timescale 1ns/1ps
module wcc_lookup #(
   parameter int LINE_BYTES = 64,
   parameter int TAG_W      = 22
) (
   input  logic [TAG_W-1:0]      line_tag,
   input  logic [LINE_BYTES-1:0] line_dirty,
   input  logic [TAG_W-1:0]      req_tag,
   input  logic [LINE_BYTES-1:0] req_mask,
   output logic                  occupied,
   output logic                  resident,
   output logic                  covers
);
   assign occupied = |line_dirty;
   assign resident = occupied && (line_tag == req_tag);
   assign covers   = ((req_mask & ~line_dirty) == '0);
endmodule

// File: rtl/wcc_wbbuf.sv
`timescale 1ns/1ps
module wcc_wbbuf #(
   parameter int LA_W       = 26,
   parameter int LINE_BYTES = 64,
   localparam int LINE_BITS = LINE_BYTES * 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap,
   input  logic [LA_W-1:0]       cap_la,
   input  logic [LINE_BITS-1:0]  cap_data,
   input  logic [LINE_BYTES-1:0] cap_mask,
   input  logic                  wb_ready,
   output logic                  wb_valid,
   output logic [LA_W-1:0]       wb_la,
   output logic [LINE_BITS-1:0]  wb_data,
   output logic [LINE_BYTES-1:0] wb_mask,
   output logic                  done
);
   assign done = wb_valid && wb_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_la    <= '0;
         wb_mask  <= '0;
      end else if (cap) begin
         wb_valid <= 1'b1;
         wb_la    <= cap_la;
         wb_mask  <= cap_mask;
      end else if (done) begin
         wb_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (cap) wb_data <= cap_data;
   end
endmodule

// File: rtl/wcache_wc.sv
`timescale 1ns/1ps
module wcache_wc
   import wcc_pkg::*;
#(
   parameter int LA_W            = 26,
   parameter int NLINES          = 16,
   parameter int LINE_BYTES      = 64,
   parameter bit HIT_DATA_MASKED = 1'b1,
   localparam int IDX_W          = $clog2(NLINES),
   localparam int TAG_W          = LA_W - IDX_W,
   localparam int LINE_BITS      = LINE_BYTES * 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  st_valid,
   output logic                  st_ready,
   input  logic [LA_W-1:0]       st_la,
   input  logic [LINE_BITS-1:0]  st_data,
   input  logic [LINE_BYTES-1:0] st_be,
   input  logic                  ld_valid,
   output logic                  ld_ready,
   input  logic [LA_W-1:0]       ld_la,
   input  logic [LINE_BYTES-1:0] ld_mask,
   output logic                  rsp_valid,
   output logic                  rsp_hit,
   output logic [LINE_BITS-1:0]  rsp_data,
   input  logic                  ev_valid,
   output logic                  ev_ready,
   input  logic [LA_W-1:0]       ev_la,
   output logic                  wb_valid,
   input  logic                  wb_ready,
   output logic [LA_W-1:0]       wb_la,
   output logic [LINE_BITS-1:0]  wb_data,
   output logic [LINE_BYTES-1:0] wb_mask,
   output logic                  inv_valid,
   output logic [LA_W-1:0]       inv_la
);
   if (NLINES < 2 || (NLINES & (NLINES - 1)) != 0) begin : g_bad_lines
      $error("wcache_wc: NLINES must be a power of two, at least 2");
   end
   if (LA_W <= IDX_W) begin : g_bad_la
      $error("wcache_wc: LA_W must exceed the index width");
   end
   if (LINE_BYTES < 1) begin : g_bad_line
      $error("wcache_wc: LINE_BYTES must be positive");
   end

   wcc_state_e state_q;
   wcc_post_e  post_q;

   logic                  idle;
   logic                  take_ev, take_st, take_ld;
   logic [LA_W-1:0]       sel_la;
   logic [IDX_W-1:0]      sel_idx;
   logic [TAG_W-1:0]      sel_tag;
   logic [LINE_BYTES-1:0] sel_mask;
   logic [TAG_W-1:0]      line_tag;
   logic [LINE_BYTES-1:0] line_dirty;
   logic [LINE_BITS-1:0]  line_data;
   logic                  occupied, resident, covers;
   logic                  ev_flush, ld_hit, ld_flush, ld_plain_miss;
   logic                  st_write, st_conflict, cap, wb_done;
   logic [LINE_BITS-1:0]  rsp_line_d;
   logic                  rsp_valid_q, rsp_hit_q;
   logic [LINE_BITS-1:0]  rsp_data_q;

   // one request per cycle, evict first, then store, then load
   assign idle     = (state_q == S_IDLE);
   assign ev_ready = idle;
   assign st_ready = idle && !ev_valid;
   assign ld_ready = idle && !ev_valid && !st_valid;
   assign take_ev  = ev_valid && ev_ready;
   assign take_st  = st_valid && st_ready;
   assign take_ld  = ld_valid && ld_ready;

   always_comb begin
      if (ev_valid)      sel_la = ev_la;
      else if (st_valid) sel_la = st_la;
      else               sel_la = ld_la;
   end
   assign sel_idx  = sel_la[IDX_W-1:0];
   assign sel_tag  = sel_la[LA_W-1:IDX_W];
   assign sel_mask = ld_mask;

   wcc_array #(.NLINES(NLINES), .LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W)) u_array (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(sel_idx), .rd_tag(line_tag), .rd_dirty(line_dirty), .rd_data(line_data),
      .wr_en(st_write), .wr_fresh(!resident), .wr_idx(sel_idx), .wr_tag(sel_tag),
      .wr_data(st_data), .wr_be(st_be),
      .clr_en(ev_flush || ld_flush), .clr_idx(sel_idx)
   );

   wcc_lookup #(.LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W)) u_lookup (
      .line_tag(line_tag), .line_dirty(line_dirty), .req_tag(sel_tag), .req_mask(sel_mask),
      .occupied(occupied), .resident(resident), .covers(covers)
   );

   assign ev_flush      = take_ev && resident;
   assign ld_hit        = take_ld && resident && covers;
   assign ld_flush      = take_ld && resident && !covers;
   assign ld_plain_miss = take_ld && !resident;
   assign st_write      = take_st && (st_be != '0);
   assign st_conflict   = st_write && occupied && !resident;
   assign cap           = ev_flush || ld_flush || st_conflict;

   wcc_wbbuf #(.LA_W(LA_W), .LINE_BYTES(LINE_BYTES)) u_wbbuf (
      .clk(clk), .rst_n(rst_n),
      .cap(cap), .cap_la({line_tag, sel_idx}), .cap_data(line_data), .cap_mask(line_dirty),
      .wb_ready(wb_ready), .wb_valid(wb_valid), .wb_la(wb_la), .wb_data(wb_data),
      .wb_mask(wb_mask), .done(wb_done)
   );

   assign inv_valid = wb_done;
   assign inv_la    = wb_la;

   if (HIT_DATA_MASKED) begin : g_rsp_masked
      for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
         assign rsp_line_d[b*8 +: 8] = ld_mask[b] ? line_data[b*8 +: 8] : 8'h00;
      end
   end else begin : g_rsp_full
      assign rsp_line_d = line_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         post_q      <= P_NONE;
         rsp_valid_q <= 1'b0;
         rsp_hit_q   <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         if (cap) begin
            state_q <= S_DRAIN;
            post_q  <= ld_flush ? P_LDMISS : P_NONE;
         end else if (wb_done) begin
            state_q <= S_IDLE;
            post_q  <= P_NONE;
         end
         rsp_valid_q <= ld_hit || ld_plain_miss || (wb_done && post_q == P_LDMISS);
         rsp_hit_q   <= ld_hit;
         rsp_data_q  <= ld_hit ? rsp_line_d : '0;
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_hit   = rsp_hit_q;
   assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/wcc_checker.sv
`timescale 1ns/1ps
module wcc_checker #(
   parameter int LA_W       = 26,
   parameter int LINE_BYTES = 64,
   localparam int LINE_BITS = LINE_BYTES * 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  st_ready,
   input logic                  ld_valid,
   input logic                  ld_ready,
   input logic                  rsp_valid,
   input logic                  rsp_hit,
   input logic                  wb_valid,
   input logic                  wb_ready,
   input logic [LA_W-1:0]       wb_la,
   input logic [LINE_BITS-1:0]  wb_data,
   input logic [LINE_BYTES-1:0] wb_mask,
   input logic                  inv_valid
);
   a_r9_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid && !wb_ready |=> wb_valid && $stable(wb_la) && $stable(wb_mask) && $stable(wb_data));

   a_r9_ports_closed: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> !st_ready && !ld_ready);

   a_r2_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> wb_mask != '0);

   a_r4_hit_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_hit |-> $past(ld_valid && ld_ready));

   a_r8_inv_single: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |=> !inv_valid);
endmodule

bind wcache_wc wcc_checker #(.LA_W(LA_W), .LINE_BYTES(LINE_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .ld_valid(ld_valid), .ld_ready(ld_ready),
   .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .wb_valid(wb_valid), .wb_ready(wb_ready),
   .wb_la(wb_la), .wb_data(wb_data), .wb_mask(wb_mask), .inv_valid(inv_valid)
);

// File: tb/sim_wcache_wc.sv
`timescale 1ns/1ps
module sim_wcache_wc;
   localparam int LA_W = 26;
   localparam int NL   = 16;
   localparam int LB   = 64;
   localparam int LBIT = LB * 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            st_valid = 0, ld_valid = 0, ev_valid = 0, wb_ready = 1;
   logic [LA_W-1:0] st_la = '0, ld_la = '0, ev_la = '0;
   logic [LBIT-1:0] st_data = '0;
   logic [LB-1:0]   st_be = '0, ld_mask = '0;
   logic            st_ready, ld_ready, ev_ready, rsp_valid, rsp_hit, wb_valid, inv_valid;
   logic [LBIT-1:0] rsp_data, wb_data;
   logic [LB-1:0]   wb_mask;
   logic [LA_W-1:0] wb_la, inv_la;

   wcache_wc u0 (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(st_ready), .st_la(st_la), .st_data(st_data), .st_be(st_be),
      .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_la(ld_la), .ld_mask(ld_mask),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_la(ev_la),
      .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_la(wb_la), .wb_data(wb_data),
      .wb_mask(wb_mask), .inv_valid(inv_valid), .inv_la(inv_la)
   );

   int n_vec = 0, n_bad = 0;
   string cur_req = "R1";

   // reference model: resident line per index, kept as plain arrays
   int              ref_la [NL];
   logic [LB-1:0]   ref_mask [NL];
   logic [LBIT-1:0] ref_data [NL];

   logic [LA_W-1:0] exp_wb_la[$], obs_wb_la[$], obs_inv_la[$];
   logic [LB-1:0]   exp_wb_mask[$], obs_wb_mask[$];
   logic [LBIT-1:0] exp_wb_data[$], obs_wb_data[$];
   logic            exp_rsp_hit[$], obs_rsp_hit[$];
   logic [LBIT-1:0] exp_rsp_data[$], obs_rsp_data[$];

   function automatic logic [LBIT-1:0] spread(input logic [LB-1:0] m);
      logic [LBIT-1:0] r = '0;
      for (int b = 0; b < LB; b++) if (m[b]) r[b*8 +: 8] = 8'hFF;
      return r;
   endfunction

   function automatic logic [LBIT-1:0] pat(input int seed);
      logic [LBIT-1:0] r;
      for (int i = 0; i < LBIT/32; i++) r[i*32 +: 32] = seed * 32'h9E3779B1 + i * 32'h01030507;
      return r;
   endfunction

   task automatic check(input bit ok, input string what, input logic [LBIT-1:0] act,
                        input logic [LBIT-1:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   task automatic push_wb(input int idx);
      exp_wb_la.push_back(LA_W'(ref_la[idx]));
      exp_wb_mask.push_back(ref_mask[idx]);
      exp_wb_data.push_back(ref_data[idx]);
      ref_la[idx]   = -1;
      ref_mask[idx] = '0;
   endtask

   task automatic ref_store(input logic [LA_W-1:0] la, input logic [LBIT-1:0] d,
                            input logic [LB-1:0] be);
      int idx = int'(la % NL);
      if (be == '0) return;
      if (ref_la[idx] != -1 && ref_la[idx] != int'(la)) push_wb(idx);
      if (ref_la[idx] != int'(la)) begin
         ref_la[idx] = int'(la);
         ref_mask[idx] = '0;
      end
      ref_data[idx] = (ref_data[idx] & ~spread(be)) | (d & spread(be));
      ref_mask[idx] |= be;
   endtask

   task automatic ref_load(input logic [LA_W-1:0] la, input logic [LB-1:0] m);
      int idx = int'(la % NL);
      if (ref_la[idx] == int'(la) && (m & ~ref_mask[idx]) == '0) begin
         exp_rsp_hit.push_back(1'b1);
         exp_rsp_data.push_back(ref_data[idx] & spread(m));
      end else begin
         if (ref_la[idx] == int'(la)) push_wb(idx);
         exp_rsp_hit.push_back(1'b0);
         exp_rsp_data.push_back('0);
      end
   endtask

   task automatic ref_evict(input logic [LA_W-1:0] la);
      int idx = int'(la % NL);
      if (ref_la[idx] == int'(la)) push_wb(idx);
   endtask

   // monitor: sample settled outputs shortly after the falling edge
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (wb_valid && wb_ready) begin
            obs_wb_la.push_back(wb_la);
            obs_wb_mask.push_back(wb_mask);
            obs_wb_data.push_back(wb_data);
         end
         if (inv_valid) obs_inv_la.push_back(inv_la);
         if (rsp_valid) begin
            obs_rsp_hit.push_back(rsp_hit);
            obs_rsp_data.push_back(rsp_data);
         end
      end
   end

   task automatic settle_compare();
      repeat (4) @(negedge clk);
      #2;
      check(obs_wb_la.size() == exp_wb_la.size(), "write-back count",
            LBIT'(obs_wb_la.size()), LBIT'(exp_wb_la.size()));
      check(obs_inv_la.size() == obs_wb_la.size(), "R8 invalidate count",
            LBIT'(obs_inv_la.size()), LBIT'(obs_wb_la.size()));
      while (obs_wb_la.size() > 0 && exp_wb_la.size() > 0) begin
         logic [LA_W-1:0] ola = obs_wb_la.pop_front(), ela = exp_wb_la.pop_front();
         logic [LB-1:0]   om = obs_wb_mask.pop_front(), em = exp_wb_mask.pop_front();
         logic [LBIT-1:0] od = obs_wb_data.pop_front(), ed = exp_wb_data.pop_front();
         check(ola == ela, "write-back address", LBIT'(ola), LBIT'(ela));
         check(om == em, "R2 write-back mask", LBIT'(om), LBIT'(em));
         check(((od ^ ed) & spread(em)) == '0, "R2 write-back dirty bytes",
               od & spread(em), ed & spread(em));
         if (obs_inv_la.size() > 0) begin
            logic [LA_W-1:0] il = obs_inv_la.pop_front();
            check(il == ola, "R8 invalidate address", LBIT'(il), LBIT'(ola));
         end
      end
      check(obs_rsp_hit.size() == exp_rsp_hit.size(), "response count",
            LBIT'(obs_rsp_hit.size()), LBIT'(exp_rsp_hit.size()));
      while (obs_rsp_hit.size() > 0 && exp_rsp_hit.size() > 0) begin
         logic oh = obs_rsp_hit.pop_front(), eh = exp_rsp_hit.pop_front();
         logic [LBIT-1:0] od = obs_rsp_data.pop_front(), ed = exp_rsp_data.pop_front();
         check(oh == eh, "hit flag", LBIT'(oh), LBIT'(eh));
         check(od == ed, "R11 response data", od, ed);
      end
      obs_wb_la.delete(); obs_wb_mask.delete(); obs_wb_data.delete(); obs_inv_la.delete();
      exp_wb_la.delete(); exp_wb_mask.delete(); exp_wb_data.delete();
      obs_rsp_hit.delete(); obs_rsp_data.delete(); exp_rsp_hit.delete(); exp_rsp_data.delete();
   endtask

   task automatic do_store(input logic [LA_W-1:0] la, input logic [LBIT-1:0] d,
                           input logic [LB-1:0] be, input string req);
      cur_req = req;
      ref_store(la, d, be);
      @(negedge clk);
      st_la = la; st_data = d; st_be = be; st_valid = 1'b1;
      #0.5;
      while (!st_ready) begin @(negedge clk); #0.5; end
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   task automatic do_load(input logic [LA_W-1:0] la, input logic [LB-1:0] m, input string req);
      cur_req = req;
      ref_load(la, m);
      @(negedge clk);
      ld_la = la; ld_mask = m; ld_valid = 1'b1;
      #0.5;
      while (!ld_ready) begin @(negedge clk); #0.5; end
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic do_evict(input logic [LA_W-1:0] la, input string req, input bit want_now);
      cur_req = req;
      ref_evict(la);
      @(negedge clk);
      ev_la = la; ev_valid = 1'b1;
      #0.5;
      if (want_now) check(ev_ready == 1'b1, "evict taken at once", LBIT'(ev_ready), LBIT'(1));
      while (!ev_ready) begin @(negedge clk); #0.5; end
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   localparam logic [LA_W-1:0] LA_A  = 26'h100;
   localparam logic [LA_W-1:0] LA_B  = 26'h200;
   localparam logic [LA_W-1:0] LA_C  = 26'h105;
   localparam logic [LA_W-1:0] LA_D  = 26'h0A7;
   localparam logic [LA_W-1:0] LA_D2 = 26'h1A7;
   localparam logic [LA_W-1:0] LA_D3 = 26'h2A7;

   initial begin
      for (int i = 0; i < NL; i++) begin ref_la[i] = -1; ref_mask[i] = '0; ref_data[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      cur_req = "R1";
      check(st_ready == 1'b1, "reset store ready", LBIT'(st_ready), LBIT'(1));
      cur_req = "R9";
      check(wb_valid == 1'b0 && inv_valid == 1'b0 && rsp_valid == 1'b0, "reset outputs idle",
            LBIT'({wb_valid, inv_valid, rsp_valid}), '0);

      // R1 / R4 / R11: store and full-cover hits
      do_store(LA_A, pat(1), 64'h0000_0000_0000_00FF, "R1");
      do_load(LA_A, 64'h0000_0000_0000_00FF, "R4");
      do_load(LA_A, 64'h0000_0000_0000_000F, "R11");
      settle_compare();

      // R6: a second writer fills other bytes and overwrites one
      do_store(LA_A, pat(2), 64'h0000_0000_0000_FF80, "R6");
      do_load(LA_A, 64'h0000_0000_0000_FFFF, "R6");
      settle_compare();

      // R5: partial cover forces a write-back, then a miss
      do_load(LA_A, 64'h0000_0000_0001_FFFF, "R5");
      settle_compare();
      do_load(LA_A, 64'h0000_0000_0000_0001, "R5");
      settle_compare();

      // R2 / R3: full line then explicit evict; R10: evict of a freed line
      do_store(LA_C, pat(3), {LB{1'b1}}, "R2");
      do_load(LA_C, {LB{1'b1}}, "R3");
      do_evict(LA_C, "R3", 1'b0);
      settle_compare();
      do_evict(LA_C, "R10", 1'b1);
      settle_compare();

      // R7: conflicting tag replaces the resident line
      do_store(LA_A, pat(4), 64'h0000_0000_0000_000F, "R7");
      do_store(LA_B, pat(5), 64'h0000_0000_0000_00F0, "R7");
      do_load(LA_B, 64'h0000_0000_0000_00F0, "R7");
      do_load(LA_B, 64'h0000_0000_0000_000F, "R7");
      settle_compare();

      // R1: zero byte enables on a conflicting tag change nothing
      do_store(LA_D, pat(6), 64'h0000_0000_0000_00FF, "R1");
      do_store(LA_D2, pat(7), 64'h0, "R1");
      do_load(LA_D, 64'h0000_0000_0000_00FF, "R1");
      settle_compare();

      // R9: back-pressure on the write-back port
      wb_ready = 1'b0;
      do_store(LA_D3, pat(8), 64'h8000_0000_0000_0001, "R9");
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); #1;
         check(wb_valid == 1'b1, "write-back held", LBIT'(wb_valid), LBIT'(1));
         check(st_ready == 1'b0 && ld_ready == 1'b0, "ports stalled",
               LBIT'({st_ready, ld_ready}), '0);
      end
      @(negedge clk);
      wb_ready = 1'b1;
      settle_compare();
      do_load(LA_D3, 64'h8000_0000_0000_0001, "R9");
      settle_compare();

      // R5: load to an empty index; R10: evict of a line no longer present
      do_load(26'h009, 64'h1, "R5");
      do_evict(LA_D, "R10", 1'b1);
      settle_compare();

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule